// File: doc/BRIEF.md
# Presettable Up/Down Counter with Carries

A four-bit synchronous counter that can be preset, cleared or stepped in either direction on each rising clock edge. A parameter chosen at elaboration sets its modulus: 10 for a decade stage or 16 for a binary stage. A low-active clear acts at once, without waiting for the clock.

Two active-low enables gate counting. One enable, the chain enable, also gates the ripple carry. Counters of any length are built by feeding the ripple carry of one stage into the chain enable of the next. A second carry output can only go low while the clock is low, so it is free of glitches. The count leaves the block on a bus that an active-low output enable can put into high impedance. A second count port is always driven and never tri-stated.

Top module: `updn_counter`

## Requirements
- R1: While `clr_async_n` is low, the count is zero at once, with no clock edge needed. This holds whatever every other input does.
- R2: A rising edge with `clr_sync_n` low sets the count to zero. This wins over load and over counting.
- R3: A rising edge with `clr_sync_n` high and `load_n` low copies `data_in` into the count. This wins over counting, and the enables have no effect on it.
- R4: With both clears and the load inactive, the count changes only when `cnt_en_n` and `chain_en_n` are both low. If either enable is high, the count holds.
- R5: When counting, `dir_up` high adds one to the count and `dir_up` low subtracts one.
- R6: With MODULUS 10, counting up goes from 9 to 0 and counting down goes from 0 to 9. With MODULUS 16, the wrap is between 15 and 0 in both directions.
- R7: With MODULUS 10, counting up from a loaded value of 10 to 15 gives 0. Counting down from such a value subtracts one.
- R8: `carry_n` is low exactly when `chain_en_n` is low and the count is at its end value. The end value is MODULUS-1 when `dir_up` is high and 0 when it is low. `carry_n` follows `dir_up` and `chain_en_n` without a clock edge.
- R9: `carry_clk_n` is low exactly when `clk` is low, `carry_n` is low and `cnt_en_n` is low. It is high during the whole high phase of the clock.
- R10: `bus_oe_n` high puts `bus_q` in high impedance, and `bus_oe_n` low drives the count onto it. Counting is the same either way, and `count_q` always shows the count.
- R11: Two decade stages, with the `carry_n` of the lower stage driving the `chain_en_n` of the upper stage, count as one two-digit decimal counter in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous actions happen on its rising edge |
| clr_async_n | input | 1 | Immediate clear, active low |
| clr_sync_n | input | 1 | Clocked clear, active low |
| load_n | input | 1 | Clocked parallel load, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| chain_en_n | input | 1 | Count enable that also gates the carries, active low |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| data_in | input | W | Value to load |
| bus_oe_n | input | 1 | Output enable for bus_q, active low |
| bus_q | output | W | Count bus that can be tri-stated |
| count_q | output | W | Count, always driven |
| carry_n | output | 1 | Ripple carry from the combinational terminal-count decode, active low |
| carry_clk_n | output | 1 | Carry gated by the clock-low phase, active low |

## Verification
The assertions check the following on every clock: clear and load priority, holding while an enable is inactive, single steps, the down wrap, returns from out-of-range values, and the conditions under which each carry may be low. Some behaviour only the bench scenarios can show. This covers the moment the immediate clear acts between edges, and the carry responding to a change of direction with no edge. It also covers the tri-stated bus, the binary and decade variants side by side, and the ripple between two cascaded decade stages. A reference model written in the bench follows all three counters, and the bench compares them with it in both clock phases.

// File: rtl/ctr_pkg.sv
`timescale 1ns/1ps
package ctr_pkg;

    typedef enum logic [2:0] {
        CTR_HOLD,
        CTR_ZERO,
        CTR_LOAD,
        CTR_INC,
        CTR_DEC
    } ctr_op_e;

    typedef struct packed {
        logic clr_s;
        logic load;
        logic run;
        logic up;
    } ctr_ctl_t;

    function automatic ctr_op_e decode_op(ctr_ctl_t c);
        if (c.clr_s)     return CTR_ZERO;
        else if (c.load) return CTR_LOAD;
        else if (c.run)  return c.up ? CTR_INC : CTR_DEC;
        else             return CTR_HOLD;
    endfunction

endpackage

// File: rtl/ctr_decode.sv
`timescale 1ns/1ps
module ctr_decode
    import ctr_pkg::*;
(
    input  ctr_ctl_t ctl,
    output ctr_op_e  op
);
    always_comb begin
        op = decode_op(ctl);
    end
endmodule

// File: rtl/ctr_step.sv
`timescale 1ns/1ps
module ctr_step
    import ctr_pkg::*;
#(
    parameter int MODULUS = 10,
    localparam int W = $clog2(MODULUS)
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    input  ctr_op_e      op,
    output logic [W-1:0] nxt
);
    if (MODULUS == (1 << W)) begin : g_bin
        always_comb begin
            unique case (op)
                CTR_ZERO: nxt = '0;
                CTR_LOAD: nxt = din;
                CTR_INC:  nxt = cur + 1'b1;
                CTR_DEC:  nxt = cur - 1'b1;
                default:  nxt = cur;
            endcase
        end
    end else begin : g_mod
        localparam logic [W-1:0] TOP = W'(MODULUS - 1);
        always_comb begin
            unique case (op)
                CTR_ZERO: nxt = '0;
                CTR_LOAD: nxt = din;
                CTR_INC:  nxt = (cur >= TOP) ? '0 : cur + 1'b1;
                CTR_DEC:  nxt = (cur == '0) ? TOP : cur - 1'b1;
                default:  nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/ctr_carry.sv
`timescale 1ns/1ps
module ctr_carry #(
    parameter int MODULUS = 10,
    localparam int W = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic [W-1:0] cur,
    input  logic         up,
    input  logic         cnt_en_n,
    input  logic         chain_en_n,
    output logic         carry_n,
    output logic         carry_clk_n
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    logic at_end;

    always_comb begin
        at_end      = up ? (cur == TOP) : (cur == '0);
        carry_n     = !(!chain_en_n && at_end);
        carry_clk_n = !(!clk && !carry_n && !cnt_en_n);
    end
endmodule

// File: rtl/updn_counter.sv
`timescale 1ns/1ps
module updn_counter
    import ctr_pkg::*;
#(
    parameter int MODULUS = 10,
    localparam int W = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         clr_async_n,
    input  logic         clr_sync_n,
    input  logic         load_n,
    input  logic         cnt_en_n,
    input  logic         chain_en_n,
    input  logic         dir_up,
    input  logic [W-1:0] data_in,
    input  logic         bus_oe_n,
    output logic [W-1:0] bus_q,
    output logic [W-1:0] count_q,
    output logic         carry_n,
    output logic         carry_clk_n
);
    ctr_ctl_t     ctl;
    ctr_op_e      op;
    logic [W-1:0] count_r;
    logic [W-1:0] count_nx;

    assign ctl = '{clr_s: !clr_sync_n,
                   load:  !load_n,
                   run:   !cnt_en_n && !chain_en_n,
                   up:    dir_up};

    ctr_decode u_decode (
        .ctl (ctl),
        .op  (op)
    );

    ctr_step #(.MODULUS(MODULUS)) u_step (
        .cur (count_r),
        .din (data_in),
        .op  (op),
        .nxt (count_nx)
    );

    always_ff @(posedge clk or negedge clr_async_n) begin
        if (!clr_async_n) count_r <= '0;
        else              count_r <= count_nx;
    end

    ctr_carry #(.MODULUS(MODULUS)) u_carry (
        .clk         (clk),
        .cur         (count_r),
        .up          (dir_up),
        .cnt_en_n    (cnt_en_n),
        .chain_en_n  (chain_en_n),
        .carry_n     (carry_n),
        .carry_clk_n (carry_clk_n)
    );

    assign count_q = count_r;
    assign bus_q   = bus_oe_n ? {W{1'bz}} : count_r;
endmodule

// File: rtl/ctr_chk.sv
`timescale 1ns/1ps
module ctr_chk #(
    parameter int MODULUS = 10,
    localparam int W = $clog2(MODULUS)
) (
    input logic         clk,
    input logic         clr_async_n,
    input logic         clr_sync_n,
    input logic         load_n,
    input logic         cnt_en_n,
    input logic         chain_en_n,
    input logic         dir_up,
    input logic [W-1:0] data_in,
    input logic [W-1:0] count_q,
    input logic         carry_n,
    input logic         carry_clk_n
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    logic stepping;
    assign stepping = clr_sync_n && load_n && !cnt_en_n && !chain_en_n;

    AST_ACLR_ZERO: assert property (@(posedge clk) !clr_async_n |-> count_q == '0); // R1
    AST_SCLR_ZERO: assert property (@(posedge clk) disable iff (!clr_async_n)
        !clr_sync_n |=> count_q == '0); // R2
    AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!clr_async_n)
        clr_sync_n && !load_n |=> count_q == $past(data_in)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_async_n)
        clr_sync_n && load_n && (cnt_en_n || chain_en_n) |=> $stable(count_q)); // R4
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!clr_async_n)
        stepping && dir_up && count_q < TOP |=> count_q == W'($past(count_q) + 1'b1)); // R5
    AST_DN_WRAP: assert property (@(posedge clk) disable iff (!clr_async_n)
        stepping && !dir_up && count_q == '0 |=> count_q == TOP); // R6
    AST_UP_RETURN: assert property (@(posedge clk) disable iff (!clr_async_n)
        stepping && dir_up && count_q >= TOP |=> count_q == '0); // R7
    AST_RCO_GATED: assert property (@(posedge clk) disable iff (!clr_async_n)
        !carry_n |-> !chain_en_n); // R8
    AST_CCO_COND: assert property (@(posedge clk) disable iff (!clr_async_n)
        !carry_clk_n |-> !carry_n && !cnt_en_n); // R9
    AST_CCO_HIGH_PHASE: assert property (@(negedge clk) disable iff (!clr_async_n)
        carry_clk_n); // R9
endmodule

bind updn_counter ctr_chk #(.MODULUS(MODULUS)) u_chk (
    .clk         (clk),
    .clr_async_n (clr_async_n),
    .clr_sync_n  (clr_sync_n),
    .load_n      (load_n),
    .cnt_en_n    (cnt_en_n),
    .chain_en_n  (chain_en_n),
    .dir_up      (dir_up),
    .data_in     (data_in),
    .count_q     (count_q),
    .carry_n     (carry_n),
    .carry_clk_n (carry_clk_n)
);

// File: tb/updn_counter_tb.sv
`timescale 1ns/1ps
module updn_counter_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic aclr_n = 1'b1, sclr_n = 1'b1, ld_n = 1'b1, enp = 1'b1, ent = 1'b1;
    logic up = 1'b1, oe_n = 1'b0;
    logic [3:0] din_lo = '0, din_hi = '0;

    logic [3:0] dec_bus, dec_cnt, bin_bus, bin_cnt, hi_bus, hi_cnt;
    logic dec_c, dec_cc, bin_c, bin_cc, hi_c, hi_cc;

    updn_counter #(.MODULUS(10)) u_dut (
        .clk(clk), .clr_async_n(aclr_n), .clr_sync_n(sclr_n), .load_n(ld_n),
        .cnt_en_n(enp), .chain_en_n(ent), .dir_up(up), .data_in(din_lo),
        .bus_oe_n(oe_n), .bus_q(dec_bus), .count_q(dec_cnt),
        .carry_n(dec_c), .carry_clk_n(dec_cc));

    updn_counter #(.MODULUS(16)) u_bin (
        .clk(clk), .clr_async_n(aclr_n), .clr_sync_n(sclr_n), .load_n(ld_n),
        .cnt_en_n(enp), .chain_en_n(ent), .dir_up(up), .data_in(din_lo),
        .bus_oe_n(oe_n), .bus_q(bin_bus), .count_q(bin_cnt),
        .carry_n(bin_c), .carry_clk_n(bin_cc));

    updn_counter #(.MODULUS(10)) u_hi (
        .clk(clk), .clr_async_n(aclr_n), .clr_sync_n(sclr_n), .load_n(ld_n),
        .cnt_en_n(enp), .chain_en_n(dec_c), .dir_up(up), .data_in(din_hi),
        .bus_oe_n(oe_n), .bus_q(hi_bus), .count_q(hi_cnt),
        .carry_n(hi_c), .carry_clk_n(hi_cc));

    int nchk = 0, nfail = 0;
    int m_dec = 0, m_bin = 0, m_hi = 0;
    string t_dec = "R1", t_bin = "R1", t_hi = "R1";

    task automatic chk(int act, int exp, string tag);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit at_end(int v, int maxv, bit chain_n);
        return !chain_n && ((up && v == maxv) || (!up && v == 0));
    endfunction

    function automatic int mstep(int v, int maxv, bit chain_n, int d, output string tag);
        if (!aclr_n)             begin tag = "R1"; return 0; end
        if (!sclr_n)             begin tag = "R2"; return 0; end
        if (!ld_n)               begin tag = "R3"; return d; end
        if (enp || chain_n)      begin tag = "R4"; return v; end
        if (up) begin
            if (v == maxv)       begin tag = "R6"; return 0; end
            if (v > maxv)        begin tag = "R7"; return 0; end
            tag = "R5"; return v + 1;
        end
        if (v == 0)              begin tag = "R6"; return maxv; end
        if (v > maxv)            begin tag = "R7"; return v - 1; end
        tag = "R5"; return v - 1;
    endfunction

    always @(posedge clk) begin
        bit lo_end;
        lo_end = at_end(m_dec, 9, ent);
        m_dec = mstep(m_dec, 9, ent, int'(din_lo), t_dec);
        m_bin = mstep(m_bin, 15, ent, int'(din_lo), t_bin);
        m_hi  = mstep(m_hi, 9, !lo_end, int'(din_hi), t_hi);
        if (t_hi != "R1" && t_hi != "R2" && t_hi != "R3") t_hi = "R11";
        #1;
        chk(int'(dec_cc), 1, "R9");
        chk(int'(bin_cc), 1, "R9");
        chk(int'(hi_cc), 1, "R9");
    end

    always @(negedge clk) begin
        bit e_dec, e_bin, e_hi;
        #1;
        if (!aclr_n) begin
            m_dec = 0; m_bin = 0; m_hi = 0;
            t_dec = "R1"; t_bin = "R1"; t_hi = "R1";
        end
        chk(int'(dec_cnt), m_dec, t_dec);
        chk(int'(bin_cnt), m_bin, t_bin);
        chk(int'(hi_cnt), m_hi, t_hi);
        e_dec = at_end(m_dec, 9, ent);
        e_bin = at_end(m_bin, 15, ent);
        e_hi  = at_end(m_hi, 9, !e_dec);
        chk(int'(dec_c), int'(!e_dec), "R8");
        chk(int'(bin_c), int'(!e_bin), "R8");
        chk(int'(hi_c), int'(!e_hi), "R11");
        chk(int'(dec_cc), int'(!(e_dec && !enp)), "R9");
        chk(int'(bin_cc), int'(!(e_bin && !enp)), "R9");
        chk(int'(hi_cc), int'(!(e_hi && !enp)), "R11");
        nchk++;
        if (oe_n) begin
            if (dec_bus !== 4'bzzzz || bin_bus !== 4'bzzzz) begin
                nfail++;
                $display("FAIL R10: actual bus %b/%b expected zzzz", dec_bus, bin_bus);
            end
        end else if (dec_bus !== 4'(m_dec) || bin_bus !== 4'(m_bin)) begin
            nfail++;
            $display("FAIL R10: actual bus %b/%b expected %0d/%0d", dec_bus, bin_bus, m_dec, m_bin);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #200000;
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        #1 aclr_n = 1'b0;                           // R1 reset state
        step(3);
        aclr_n = 1'b1;
        step(1);
        ld_n = 1'b0; din_lo = 4'd7; din_hi = 4'd8;  // R3, enables inactive
        step(1);
        ld_n = 1'b1; enp = 1'b0; ent = 1'b0; up = 1'b1;
        step(6);                                    // R5, R6 up wrap, R11
        enp = 1'b1; step(2);                        // R4
        enp = 1'b0; ent = 1'b1; step(2);            // R4, R8 gated
        ent = 1'b0;
        up = 1'b0; step(6);                         // R5 down, R6, R8 no edge
        oe_n = 1'b1; step(3);                       // R10
        oe_n = 1'b0;
        sclr_n = 1'b0; ld_n = 1'b0; din_lo = 4'd5;  // R2 over load
        step(1);
        sclr_n = 1'b1; ld_n = 1'b1; step(2);
        ld_n = 1'b0; din_lo = 4'd13; step(1);       // R7 up
        ld_n = 1'b1; up = 1'b1; step(3);
        ld_n = 1'b0; din_lo = 4'd12; up = 1'b0; step(1);  // R7 down
        ld_n = 1'b1; step(4);
        aclr_n = 1'b0; step(1);                     // R1 mid-run
        aclr_n = 1'b1;
        ld_n = 1'b0; din_lo = 4'd5; din_hi = 4'd8; step(1);
        ld_n = 1'b1; up = 1'b1; step(40);           // R11 up cascade
        up = 1'b0; step(40);                        // R11 down cascade
        finish_run();
    end
endmodule